// File: doc/BRIEF.md
# DMA Channel Interrupt Status Bank

This block keeps, for every channel of a DMA controller, a 6-bit interrupt enable register and a status register, and drives one interrupt line per channel. The transfer engine reports completion and error conditions as single-cycle event pulses. An event is recorded in status only when its enable bit is set. Any recorded bit raises the channel's line. Software reads status through a 16-bit register port with a channel select. A read returns the status and clears it, but the sync-in-progress bit is kept because it mirrors live channel state.

A legacy mode pairs channel k with channel k+6 for k in 0..2. In this mode the pair shares the low line: that line ORs both channels. A status read on either member returns the partner's event bits in the upper field and clears both channels. The enable register is the only writable field. The status register ignores writes.

Top module: `dma_irq_status`

## Requirements
- R1: After reset every channel's enable register reads 0x0003, every status register reads 0x0000 and every interrupt line is low.
- R2: A write with addr_i=0 to channel sel_i stores wdata_i[5:0] as that channel's enable. A read with addr_i=0 returns it in bits 5:0 with bits 15:6 zero, and does not alter status.
- R3: Status bits 5:0 are event bits: bit0 timeout, bit1 end of block, bit2 end of frame, bit3 half frame, bit4 last frame, bit5 end of packet. Event input bit b of a channel sets status bit b one cycle later only when enable bit b is set.
- R4: A status read (addr_i=1, rd_en_i=1) returns the status combinationally in that cycle. At the next clock edge it clears bits 5:0 and keeps bit 6.
- R5: Status bit 6 is the sync-in-progress flag. It equals active_i & sync_mode_i of the channel as registered at the previous edge, and it never raises an interrupt line.
- R6: With legacy_i=0, line c is high exactly when any of channel c's status bits 5:0 is set.
- R7: With legacy_i=1, lines 0..2 are the OR of channel k and channel k+6 event bits. Lines 3..5 follow their own channel. Lines 6..8 are held low.
- R8: With legacy_i=1, a status read on channel k or k+6 (k in 0..2) ORs the partner's bits 5:0 into read bits 11:6 and clears the partner's event bits at the same edge.
- R9: An enabled event arriving in the same cycle as a status read of its channel is recorded after the clear, not lost.
- R10: Writes with addr_i=1 leave status unchanged. A select at or beyond the channel count reads zero and clears or writes nothing.
- R11: A status read with no coincident enabled event leaves the channel's line low after the clearing edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| legacy_i | input | 1 | Pair-merge mode |
| evt_i | input | NUM_CH*6 | Event pulses, 6 bits per channel, channel 0 lowest |
| active_i | input | NUM_CH | Channel currently active |
| sync_mode_i | input | NUM_CH | Channel is request-synchronised |
| sel_i | input | CH_W | Channel select for register access |
| addr_i | input | 1 | 0 enable register, 1 status register |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, valid in the strobe cycle |
| irq_o | output | NUM_CH | Interrupt lines |

## Verification
A status read and an engine event can land on the same channel in the same cycle. The bench drives an event pulse into the cycle that carries a read strobe. It then checks two things. The read data must show only the status before the pulse. The register must hold the new bit afterwards, with the line still high. The same collision is checked with the reader on one member of a legacy pair. In that case the clearing edge also reaches the partner register. Every read is compared against a cycle-level model of the requirements kept in the bench. The sweeps cover every enable pattern on every channel.

// File: rtl/dma_irq_pkg.sv
`timescale 1ns/1ps
package dma_irq_pkg;
  localparam int EVT_W  = 6;
  localparam int STAT_W = EVT_W + 1;
  localparam int REG_W  = 16;
  localparam logic [EVT_W-1:0] EN_RST = 6'h03;
  localparam logic ADDR_EN   = 1'b0;
  localparam logic ADDR_STAT = 1'b1;
  localparam int EV_TIMEOUT  = 0;
  localparam int EV_BLOCK    = 1;
  localparam int EV_FRAME    = 2;
  localparam int EV_HALF     = 3;
  localparam int EV_LAST     = 4;
  localparam int EV_PKT      = 5;
endpackage

// File: rtl/dma_irq_chan.sv
`timescale 1ns/1ps
module dma_irq_chan
  import dma_irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_we_i,
  input  logic [EVT_W-1:0]  en_wdata_i,
  input  logic [EVT_W-1:0]  evt_i,
  input  logic              sync_i,
  input  logic              clr_i,
  output logic [EVT_W-1:0]  en_o,
  output logic [STAT_W-1:0] stat_o
);
  logic [EVT_W-1:0] en_q;
  logic [EVT_W-1:0] ev_q;
  logic             sync_q;
  logic [EVT_W-1:0] ev_kept;

  // clear first, then merge new events so a coincident event survives
  assign ev_kept = clr_i ? '0 : ev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= EN_RST;
      ev_q   <= '0;
      sync_q <= 1'b0;
    end else begin
      if (en_we_i) en_q <= en_wdata_i;
      ev_q   <= ev_kept | (evt_i & en_q);
      sync_q <= sync_i;
    end
  end

  assign en_o   = en_q;
  assign stat_o = {sync_q, ev_q};
endmodule

// File: rtl/dma_irq_merge.sv
`timescale 1ns/1ps
module dma_irq_merge
  import dma_irq_pkg::*;
#(
  parameter int NUM_CH    = 9,
  parameter int PAIR_BASE = 6,
  parameter int PAIR_NUM  = 3
) (
  input  logic                    legacy_i,
  input  logic [NUM_CH*EVT_W-1:0] ev_i,
  output logic [NUM_CH-1:0]       irq_o
);
  logic [NUM_CH-1:0] own;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_line
    assign own[c] = |ev_i[c*EVT_W +: EVT_W];
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_map
    if (c < PAIR_NUM && c + PAIR_BASE < NUM_CH) begin : g_low
      assign irq_o[c] = own[c] | (legacy_i & own[c+PAIR_BASE]);
    end else if (c >= PAIR_BASE && c < PAIR_BASE + PAIR_NUM) begin : g_high
      assign irq_o[c] = own[c] & ~legacy_i;
    end else begin : g_solo
      assign irq_o[c] = own[c];
    end
  end
endmodule

// File: rtl/dma_irq_rdport.sv
`timescale 1ns/1ps
module dma_irq_rdport
  import dma_irq_pkg::*;
#(
  parameter int NUM_CH    = 9,
  parameter int PAIR_BASE = 6,
  parameter int PAIR_NUM  = 3,
  parameter int CH_W      = 4
) (
  input  logic                     legacy_i,
  input  logic                     rd_en_i,
  input  logic [CH_W-1:0]          sel_i,
  input  logic                     addr_i,
  input  logic [NUM_CH*EVT_W-1:0]  en_i,
  input  logic [NUM_CH*STAT_W-1:0] stat_i,
  output logic [REG_W-1:0]         rdata_o,
  output logic [NUM_CH-1:0]        clr_o
);
  int                sel_n;
  int                pidx;
  logic              in_rng;
  logic              has_p;
  logic [EVT_W-1:0]  en_own;
  logic [STAT_W-1:0] st_own;
  logic [EVT_W-1:0]  pst;

  always_comb begin
    sel_n  = int'(sel_i);
    in_rng = sel_n < NUM_CH;
    has_p  = 1'b0;
    pidx   = -1;
    if (sel_n < PAIR_NUM && sel_n + PAIR_BASE < NUM_CH) begin
      pidx  = sel_n + PAIR_BASE;
      has_p = 1'b1;
    end else if (sel_n >= PAIR_BASE && sel_n < PAIR_BASE + PAIR_NUM && sel_n < NUM_CH) begin
      pidx  = sel_n - PAIR_BASE;
      has_p = 1'b1;
    end
    has_p = has_p & legacy_i;

    en_own = '0;
    st_own = '0;
    pst    = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (sel_n == c) begin
        en_own = en_i[c*EVT_W +: EVT_W];
        st_own = stat_i[c*STAT_W +: STAT_W];
      end
      if (has_p && pidx == c) pst = stat_i[c*STAT_W +: EVT_W];
    end

    rdata_o = '0;
    if (in_rng) begin
      if (addr_i == ADDR_EN) rdata_o = REG_W'(en_own);
      else                   rdata_o = REG_W'(st_own) | (REG_W'(pst) << EVT_W);
    end

    for (int c = 0; c < NUM_CH; c++) begin
      clr_o[c] = rd_en_i && (addr_i == ADDR_STAT) && in_rng &&
                 ((sel_n == c) || (has_p && pidx == c));
    end
  end
endmodule

// File: rtl/dma_irq_status.sv
`timescale 1ns/1ps
module dma_irq_status
  import dma_irq_pkg::*;
#(
  parameter int NUM_CH    = 9,
  parameter int PAIR_BASE = 6,
  parameter int PAIR_NUM  = 3,
  parameter int CH_W      = $clog2(NUM_CH)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    legacy_i,
  input  logic [NUM_CH*EVT_W-1:0] evt_i,
  input  logic [NUM_CH-1:0]       active_i,
  input  logic [NUM_CH-1:0]       sync_mode_i,
  input  logic [CH_W-1:0]         sel_i,
  input  logic                    addr_i,
  input  logic                    wr_en_i,
  input  logic                    rd_en_i,
  input  logic [REG_W-1:0]        wdata_i,
  output logic [REG_W-1:0]        rdata_o,
  output logic [NUM_CH-1:0]       irq_o
);
  logic [NUM_CH-1:0]        en_we;
  logic [NUM_CH-1:0]        clr;
  logic [NUM_CH*EVT_W-1:0]  en_flat;
  logic [NUM_CH*STAT_W-1:0] stat_flat;
  logic [NUM_CH*EVT_W-1:0]  ev_flat;
  logic                     unused_wdata;

  assign unused_wdata = ^wdata_i[REG_W-1:EVT_W];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign en_we[c] = wr_en_i && (addr_i == ADDR_EN) && (int'(sel_i) == c);

    dma_irq_chan u_chan (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .en_we_i    (en_we[c]),
      .en_wdata_i (wdata_i[EVT_W-1:0]),
      .evt_i      (evt_i[c*EVT_W +: EVT_W]),
      .sync_i     (active_i[c] & sync_mode_i[c]),
      .clr_i      (clr[c]),
      .en_o       (en_flat[c*EVT_W +: EVT_W]),
      .stat_o     (stat_flat[c*STAT_W +: STAT_W])
    );

    assign ev_flat[c*EVT_W +: EVT_W] = stat_flat[c*STAT_W +: EVT_W];
  end

  dma_irq_rdport #(
    .NUM_CH(NUM_CH), .PAIR_BASE(PAIR_BASE), .PAIR_NUM(PAIR_NUM), .CH_W(CH_W)
  ) u_rdport (
    .legacy_i (legacy_i),
    .rd_en_i  (rd_en_i),
    .sel_i    (sel_i),
    .addr_i   (addr_i),
    .en_i     (en_flat),
    .stat_i   (stat_flat),
    .rdata_o  (rdata_o),
    .clr_o    (clr)
  );

  dma_irq_merge #(
    .NUM_CH(NUM_CH), .PAIR_BASE(PAIR_BASE), .PAIR_NUM(PAIR_NUM)
  ) u_merge (
    .legacy_i (legacy_i),
    .ev_i     (ev_flat),
    .irq_o    (irq_o)
  );
endmodule

// File: rtl/dma_irq_status_chk.sv
`timescale 1ns/1ps
module dma_irq_status_chk
  import dma_irq_pkg::*;
#(
  parameter int NUM_CH    = 9,
  parameter int PAIR_BASE = 6,
  parameter int PAIR_NUM  = 3,
  parameter int CH_W      = 4
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    legacy_i,
  input logic [NUM_CH*EVT_W-1:0] evt_i,
  input logic [CH_W-1:0]         sel_i,
  input logic                    addr_i,
  input logic                    rd_en_i,
  input logic [NUM_CH*EVT_W-1:0] en_all,
  input logic [NUM_CH*EVT_W-1:0] ev_all,
  input logic [NUM_CH-1:0]       irq_o
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_c
    // R3
    en_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |=> ((ev_all[c*EVT_W +: EVT_W] & ~$past(ev_all[c*EVT_W +: EVT_W])
                 & ~$past(en_all[c*EVT_W +: EVT_W])) == '0));
    // R4
    rd_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_en_i && addr_i == ADDR_STAT && int'(sel_i) == c && evt_i[c*EVT_W +: EVT_W] == '0)
      |=> (ev_all[c*EVT_W +: EVT_W] == '0));
    // R5
    sync_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!legacy_i && ev_all[c*EVT_W +: EVT_W] == '0) |-> !irq_o[c]);
    // R6
    own_line_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !legacy_i |-> (irq_o[c] == (|ev_all[c*EVT_W +: EVT_W])));
    if (c >= PAIR_BASE && c < PAIR_BASE + PAIR_NUM) begin : g_hi
      // R7
      legacy_hi_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        legacy_i |-> !irq_o[c]);
    end
    if (c < PAIR_NUM && c + PAIR_BASE < NUM_CH) begin : g_lo
      // R8
      partner_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_en_i && legacy_i && addr_i == ADDR_STAT && int'(sel_i) == c
         && evt_i[(c+PAIR_BASE)*EVT_W +: EVT_W] == '0)
        |=> (ev_all[(c+PAIR_BASE)*EVT_W +: EVT_W] == '0));
    end
  end
endmodule

bind dma_irq_status dma_irq_status_chk #(
  .NUM_CH(NUM_CH), .PAIR_BASE(PAIR_BASE), .PAIR_NUM(PAIR_NUM), .CH_W(CH_W)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .legacy_i (legacy_i),
  .evt_i    (evt_i),
  .sel_i    (sel_i),
  .addr_i   (addr_i),
  .rd_en_i  (rd_en_i),
  .en_all   (en_flat),
  .ev_all   (ev_flat),
  .irq_o    (irq_o)
);

// File: tb/dma_irq_status_test.sv
`timescale 1ns/1ps
module dma_irq_status_test;
  localparam int NCH = 9;

  logic            clk = 1'b0;
  logic            rst_ni = 1'b0;
  logic            legacy = 1'b0;
  logic [NCH*6-1:0] evt = '0;
  logic [NCH-1:0]  act = '0;
  logic [NCH-1:0]  syn = '0;
  logic [3:0]      sel = '0;
  logic            addr = 1'b0;
  logic            wr = 1'b0;
  logic            rd = 1'b0;
  logic [15:0]     wdata = '0;
  logic [15:0]     rdata;
  logic [NCH-1:0]  irq;

  int checks = 0;
  int errors = 0;

  logic [5:0] en_m [NCH];
  logic [5:0] ev_m [NCH];
  logic       sy_m [NCH];

  always #2.5 clk = ~clk;

  dma_irq_status uut (
    .clk_i(clk), .rst_ni(rst_ni), .legacy_i(legacy), .evt_i(evt),
    .active_i(act), .sync_mode_i(syn), .sel_i(sel), .addr_i(addr),
    .wr_en_i(wr), .rd_en_i(rd), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  function automatic int partner(input int c);
    if (c < 3) return c + 6;
    if (c >= 6 && c < 9) return c - 6;
    return -1;
  endfunction

  function automatic logic [NCH-1:0] exp_irq();
    logic [NCH-1:0] v;
    for (int l = 0; l < NCH; l++) begin
      if (legacy && l < 3)       v[l] = (|ev_m[l]) | (|ev_m[l+6]);
      else if (legacy && l >= 6) v[l] = 1'b0;
      else                       v[l] = |ev_m[l];
    end
    return v;
  endfunction

  function automatic logic [15:0] exp_rd(input int s, input logic a);
    logic [15:0] v;
    int p;
    if (s >= NCH) return 16'h0;
    if (a == 1'b0) return {10'h0, en_m[s]};
    v = {9'h0, sy_m[s], ev_m[s]};
    p = partner(s);
    if (legacy && p >= 0) v = v | ({10'h0, ev_m[p]} << 6);
    return v;
  endfunction

  task automatic chk(input string tag, input logic [31:0] a, input logic [31:0] e);
    checks++;
    if (a !== e) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, a, e);
    end
  endtask

  task automatic cyc();
    logic [5:0] nen [NCH];
    logic [5:0] nev [NCH];
    logic       nsy [NCH];
    int s;
    s = int'(sel);
    for (int c = 0; c < NCH; c++) begin
      logic clr;
      clr = rd && addr && s < NCH && (s == c || (legacy && partner(s) == c));
      nev[c] = (clr ? 6'h0 : ev_m[c]) | (evt[c*6 +: 6] & en_m[c]);
      nen[c] = (wr && !addr && s == c) ? wdata[5:0] : en_m[c];
      nsy[c] = act[c] & syn[c];
    end
    @(posedge clk);
    @(negedge clk);
    for (int c = 0; c < NCH; c++) begin
      ev_m[c] = nev[c]; en_m[c] = nen[c]; sy_m[c] = nsy[c];
    end
    wr = 1'b0; rd = 1'b0; evt = '0;
  endtask

  task automatic wr_en(input int c, input logic [5:0] v);
    sel = 4'(c); addr = 1'b0; wr = 1'b1; wdata = {10'h3FF, v};
    cyc();
  endtask

  task automatic rd_reg(input string tag, input int c, input logic a, input logic strobe);
    logic [15:0] e;
    sel = 4'(c); addr = a; rd = strobe;
    #1;
    e = exp_rd(c, a);
    chk(tag, 32'(rdata), 32'(e));
    cyc();
  endtask

  initial begin
    for (int c = 0; c < NCH; c++) begin
      en_m[c] = 6'h03; ev_m[c] = '0; sy_m[c] = 1'b0;
    end
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq", 32'(irq), 32'h0);
    for (int c = 0; c < NCH; c++) begin
      rd_reg("R1 enable", c, 1'b0, 1'b1);
      rd_reg("R1 status", c, 1'b1, 1'b1);
    end

    // R2 enable write and read back
    for (int c = 0; c < NCH; c++) wr_en(c, 6'((c * 11 + 5) & 63));
    for (int c = 0; c < NCH; c++) rd_reg("R2 enable readback", c, 1'b0, 1'b1);

    // R3 R4 R6 R11 sweep over every enable pattern
    legacy = 1'b0;
    for (int c = 0; c < NCH; c++) begin
      for (int e = 0; e < 64; e++) begin
        wr_en(c, 6'(e));
        evt[c*6 +: 6] = 6'((e * 5 + c * 3 + 1) & 63);
        cyc();
        chk("R6 own line", 32'(irq), 32'(exp_irq()));
        rd_reg("R3 gated status", c, 1'b1, 1'b1);
        chk("R11 line low after read", 32'(irq[c]), 32'h0);
        rd_reg("R4 cleared", c, 1'b1, 1'b1);
      end
    end

    // R5 sync bit
    wr_en(4, 6'h3F);
    act[4] = 1'b1; syn[4] = 1'b1;
    cyc();
    chk("R5 sync no irq", 32'(irq), 32'h0);
    rd_reg("R5 sync set", 4, 1'b1, 1'b1);
    rd_reg("R4 sync kept", 4, 1'b1, 1'b1);
    chk("R5 sync bit value", 32'(sy_m[4]), 32'h1);
    syn[4] = 1'b0;
    cyc();
    rd_reg("R5 sync off", 4, 1'b1, 1'b1);
    act[4] = 1'b0;

    // R9 event with read in same cycle
    wr_en(2, 6'h3F);
    evt[2*6 +: 6] = 6'h01;
    cyc();
    evt[2*6 +: 6] = 6'h08;
    rd_reg("R9 read sees old", 2, 1'b1, 1'b1);
    chk("R9 line held", 32'(irq[2]), 32'h1);
    rd_reg("R9 event kept", 2, 1'b1, 1'b1);

    // R7 R8 legacy merge
    legacy = 1'b1;
    for (int c = 0; c < NCH; c++) wr_en(c, 6'h3F);
    for (int c = 0; c < NCH; c++) begin
      evt[c*6 +: 6] = 6'(1 << (c % 6));
      cyc();
      chk("R7 merged lines", 32'(irq), 32'(exp_irq()));
      rd_reg("R8 merged read", c, 1'b1, 1'b1);
      chk("R8 pair cleared", 32'(irq), 32'h0);
    end
    for (int k = 0; k < 3; k++) begin
      evt[k*6 +: 6] = 6'h21;
      evt[(k+6)*6 +: 6] = 6'h12;
      cyc();
      chk("R7 pair line", 32'(irq), 32'(exp_irq()));
      // reader on high member, coincident event on low member
      evt[k*6 +: 6] = 6'h04;
      rd_reg("R8 read high member", k + 6, 1'b1, 1'b1);
      chk("R9 partner event kept", 32'(ev_m[k]), 32'h04);
      rd_reg("R8 read low member", k, 1'b1, 1'b1);
      chk("R8 both clear", 32'(irq), 32'h0);
    end

    // R10 status writes ignored, out-of-range select
    legacy = 1'b0;
    evt[5*6 +: 6] = 6'h3F;
    wr_en(5, 6'h3F);
    evt[5*6 +: 6] = 6'h3F;
    cyc();
    sel = 4'd5; addr = 1'b1; wr = 1'b1; wdata = 16'h0000;
    cyc();
    rd_reg("R10 status write ignored", 5, 1'b1, 1'b0);
    rd_reg("R10 out of range read", 12, 1'b1, 1'b1);
    chk("R10 line unchanged", 32'(irq), 32'(exp_irq()));
    sel = 4'd15; addr = 1'b0; wr = 1'b1; wdata = 16'h0000;
    cyc();
    for (int c = 0; c < NCH; c++) rd_reg("R10 enables unchanged", c, 1'b0, 1'b1);
    rd_reg("R10 status still set", 5, 1'b1, 1'b1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule